// File: doc/BRIEF.md
# Multi-Mode Clock-Enable Divider

This block turns a stream of input enable cycles into a slower stream of single-cycle enable pulses. Downstream logic uses these pulses as a clock enable. It counts only the cycles in which its enable input is high. Each time it has counted a full period, it raises a one-cycle pulse on `tick_o`.

The period length comes from a divisor field and a mode selector. The modes are:
- linear: field plus one;
- doubled: twice (low field bits plus one);
- shift: two to the power of the low field bits;
- fixed: a constant set at build time.

For even periods the block also drives a square-wave output, `half_o`, with 50% duty. This output is low during the first half of each period and high during the second half.

The block samples a new field or mode only in the cycle that ends a period, so no period is ever cut short. After reset it samples the inputs on the first enabled cycle.

Top module: `clk_en_divider`

## Requirements
- R1: Mode 2'b00 (linear) produces one `tick_o` pulse every field+1 enabled cycles. All FIELD_W field bits are used, so the period runs from 1 to 32 with the default width.
- R2: Mode 2'b01 (doubled) produces one pulse every 2×(field[DBL_W-1:0]+1) enabled cycles. Field bits at DBL_W and above are ignored.
- R3: Mode 2'b10 (shift) produces one pulse every 2^field[SHF_W-1:0] enabled cycles. Field bits at SHF_W and above are ignored.
- R4: Mode 2'b11 (fixed) produces one pulse every CONST_DIV enabled cycles, whatever the field value (default 3).
- R5: A period of 1 asserts `tick_o` in every cycle in which `en_i` is high.
- R6: Mode and field are sampled only in the cycle that carries a pulse, and the new period starts in the next cycle. A change made in the middle of a period does not shorten or lengthen that period.
- R7: While `en_i` is low the period count holds and `tick_o` stays low. Counting resumes where it stopped.
- R8: For an even period P, `half_o` is low while the position in the period is below P/2 and high from P/2 to P-1. For an odd period `half_o` stays low.
- R9: While `rst_n` is low, `tick_o` and `half_o` are low. After reset the first period uses the mode and field present on the first enabled cycle, and its pulse falls on the P-th enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Input enable; only cycles with this high are counted |
| mode_i | input | 2 | 00 linear, 01 doubled, 10 shift, 11 fixed |
| field_i | input | FIELD_W | Divisor field |
| tick_o | output | 1 | One-cycle pulse on the last enabled cycle of each period |
| half_o | output | 1 | 50% duty square wave for even periods, registered |

## Verification
`tick_o` depends combinationally on `en_i` in the same cycle, combined with the registered position in the period. It is therefore checked in the cycle the stimulus is applied. `half_o` is registered: it rises in the cycle after the position P/2-1 is counted, and it falls in the cycle after the pulse.

The driver applies inputs one time unit after a rising edge and queues the expected pair of values for that same cycle. The monitor compares the pair at the following falling edge, so every expectation lines up with the register stages counted above.

Each expected period length is a constant written into the stimulus, including the transition periods in which new settings are present but not yet sampled.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    typedef enum logic [1:0] {
        DIV_LINEAR = 2'b00,
        DIV_DOUBLE = 2'b01,
        DIV_SHIFT  = 2'b10,
        DIV_FIXED  = 2'b11
    } div_mode_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cdiv_ratio_dec.sv
// Turns mode and field into a period length in enabled cycles.
module cdiv_ratio_dec
    import cdiv_pkg::*;
#(
    parameter int FIELD_W   = 5,
    parameter int DBL_W     = 4,
    parameter int SHF_W     = 3,
    parameter int CONST_DIV = 3,
    parameter bit HAS_FIXED = 1'b1,
    parameter int RW        = 8
) (
    input  div_mode_e          mode_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [RW-1:0]      ratio_o
);

    logic [RW-1:0] lin_r;
    logic [RW-1:0] dbl_r;
    logic [RW-1:0] shf_r;
    logic [RW-1:0] fix_r;

    always_comb begin
        lin_r = RW'(field_i) + RW'(1);
        dbl_r = (RW'(field_i[DBL_W-1:0]) + RW'(1)) << 1;
        shf_r = RW'(1) << field_i[SHF_W-1:0];
    end

    // The fixed variant is optional; without it mode 11 falls back to linear.
    generate
        if (HAS_FIXED) begin : g_fixed
            assign fix_r = RW'(CONST_DIV);
        end else begin : g_no_fixed
            assign fix_r = lin_r;
        end
    endgenerate

    always_comb begin
        unique case (mode_i)
            DIV_LINEAR: ratio_o = lin_r;
            DIV_DOUBLE: ratio_o = dbl_r;
            DIV_SHIFT:  ratio_o = shf_r;
            default:    ratio_o = fix_r;
        endcase
    end

endmodule

// File: rtl/cdiv_period_ctr.sv
// Counts enabled cycles and samples a new period length only at terminal count.
module cdiv_period_ctr #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic [RW-1:0] live_ratio_i,
    output logic          tick_o,
    output logic          term_o,
    output logic [RW-1:0] cnt_o,
    output logic [RW-1:0] ratio_o,
    output logic          fresh_o
);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic [RW-1:0] ratio;
        logic          fresh;
    } ctr_t;

    ctr_t s_d, s_q;
    logic [RW-1:0] act_ratio;
    logic          at_term;

    always_comb begin
        // Until the first enabled cycle the live inputs define the period.
        act_ratio = s_q.fresh ? live_ratio_i : s_q.ratio;
        at_term   = (s_q.cnt == act_ratio - RW'(1));
        s_d       = s_q;
        if (en_i) begin
            if (at_term) begin
                s_d.cnt   = '0;
                s_d.ratio = live_ratio_i;
                s_d.fresh = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + RW'(1);
                if (s_q.fresh) begin
                    s_d.ratio = live_ratio_i;
                    s_d.fresh = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt   <= '0;
            s_q.ratio <= RW'(1);
            s_q.fresh <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign term_o  = at_term;
    assign tick_o  = rst_n & en_i & at_term;
    assign cnt_o   = s_q.cnt;
    assign ratio_o = act_ratio;
    assign fresh_o = s_q.fresh;

endmodule

// File: rtl/cdiv_half_gen.sv
// Square-wave output: high over the second half of an even period.
module cdiv_half_gen #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          tick_i,
    input  logic [RW-1:0] cnt_i,
    input  logic [RW-1:0] ratio_i,
    output logic          half_o
);

    typedef struct packed {
        logic half;
    } half_t;

    half_t h_d, h_q;
    logic  even_ratio;
    logic  at_mid;

    always_comb begin
        even_ratio = ~ratio_i[0];
        at_mid     = (cnt_i == ((ratio_i >> 1) - RW'(1)));
        h_d        = h_q;
        if (tick_i) begin
            h_d.half = 1'b0;
        end else if (en_i && even_ratio && at_mid) begin
            h_d.half = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.half <= 1'b0;
        end else begin
            h_q <= h_d;
        end
    end

    assign half_o = h_q.half;

endmodule

// File: rtl/clk_en_divider.sv
module clk_en_divider
    import cdiv_pkg::*;
#(
    parameter int FIELD_W   = 5,
    parameter int DBL_W     = 4,
    parameter int SHF_W     = 3,
    parameter int CONST_DIV = 3,
    parameter bit HAS_FIXED = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [1:0]         mode_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic               tick_o,
    output logic               half_o
);

    localparam int LIN_MAX   = 1 << FIELD_W;
    localparam int DBL_MAX   = 2 << DBL_W;
    localparam int SHF_MAX   = 1 << ((1 << SHF_W) - 1);
    localparam int RATIO_MAX = imax(imax(LIN_MAX, DBL_MAX), imax(SHF_MAX, CONST_DIV));
    localparam int RW        = $clog2(RATIO_MAX + 1);

    logic [RW-1:0] live_ratio_w;
    logic [RW-1:0] cnt_w;
    logic [RW-1:0] ratio_w;
    logic          fresh_w;
    logic          term_w;
    logic          tick_w;

    cdiv_ratio_dec #(
        .FIELD_W  (FIELD_W),
        .DBL_W    (DBL_W),
        .SHF_W    (SHF_W),
        .CONST_DIV(CONST_DIV),
        .HAS_FIXED(HAS_FIXED),
        .RW       (RW)
    ) u_dec (
        .mode_i (div_mode_e'(mode_i)),
        .field_i(field_i),
        .ratio_o(live_ratio_w)
    );

    cdiv_period_ctr #(
        .RW(RW)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .live_ratio_i(live_ratio_w),
        .tick_o      (tick_w),
        .term_o      (term_w),
        .cnt_o       (cnt_w),
        .ratio_o     (ratio_w),
        .fresh_o     (fresh_w)
    );

    cdiv_half_gen #(
        .RW(RW)
    ) u_half (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .tick_i (tick_w),
        .cnt_i  (cnt_w),
        .ratio_i(ratio_w),
        .half_o (half_o)
    );

    assign tick_o = tick_w;

endmodule

// File: rtl/clk_en_divider_chk.sv
module clk_en_divider_chk #(
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_i,
    input logic          tick_o,
    input logic          half_o,
    input logic [RW-1:0] cnt,
    input logic [RW-1:0] ratio,
    input logic          fresh
);

    AST_TICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> en_i);  // R7

    AST_IDLE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt));  // R7

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < ratio);  // R1

    AST_RATIO_HELD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_o && !fresh) |=> $stable(ratio));  // R6

    AST_HALF_ONLY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        half_o |-> !ratio[0]);  // R8

    AST_RATIO_ONE_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ratio == RW'(1)) |-> tick_o);  // R5

    always @(posedge clk) begin
        if (rst_n === 1'b0) begin
            AST_RST_QUIET: assert (!tick_o && !half_o);  // R9
        end
    end

endmodule

bind clk_en_divider clk_en_divider_chk #(.RW(RW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en_i),
    .tick_o(tick_o),
    .half_o(half_o),
    .cnt   (cnt_w),
    .ratio (ratio_w),
    .fresh (fresh_w)
);

// File: tb/tb_clk_en_divider.sv
`timescale 1ns/1ps
module tb_clk_en_divider;

    localparam int FW = 5;
    localparam logic [1:0] M_LIN = 2'b00;
    localparam logic [1:0] M_DBL = 2'b01;
    localparam logic [1:0] M_SHF = 2'b10;
    localparam logic [1:0] M_FIX = 2'b11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en_i = 1'b0;
    logic [1:0]    mode_i = M_LIN;
    logic [FW-1:0] field_i = '0;
    logic          tick_o;
    logic          half_o;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit    tick;
        bit    half;
        string req;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    clk_en_divider dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .mode_i (mode_i),
        .field_i(field_i),
        .tick_o (tick_o),
        .half_o (half_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Drive one cycle and queue the expected output pair for that cycle.
    task automatic drive(input bit en, input logic [1:0] m, input logic [FW-1:0] f,
                         input bit tk, input bit hf, input string req);
        exp_t e;
        @(posedge clk);
        #1;
        en_i    = en;
        mode_i  = m;
        field_i = f;
        e.tick  = tk;
        e.half  = hf;
        e.req   = req;
        sb_q.push_back(e);
    endtask

    // One full period of length p; optional enable gap before position gap_at.
    task automatic run_period(input logic [1:0] m, input logic [FW-1:0] f, input int p,
                              input string req, input int gap_at = -1, input int gap_len = 0);
        for (int j = 0; j < p; j++) begin
            bit hv;
            hv = ((p % 2) == 0) && (j >= p / 2);
            if (j == gap_at) begin
                for (int g = 0; g < gap_len; g++) begin
                    drive(1'b0, m, f, 1'b0, hv, "R7");
                end
            end
            drive(1'b1, m, f, (j == p - 1), hv, req);
        end
    endtask

    // Monitor: compare at the falling edge of the cycle the item was queued in.
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(tick_o == e.tick, e.req, "tick_o", int'(tick_o), int'(e.tick));
                check(half_o == e.half, e.req, "half_o", int'(half_o), int'(e.half));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R9: outputs quiet during reset, even with enable high and ratio 1.
        en_i = 1'b1;
        mode_i = M_LIN;
        field_i = '0;
        repeat (3) begin
            @(negedge clk);
            check(tick_o == 1'b0, "R9", "tick_o in reset", int'(tick_o), 0);
            check(half_o == 1'b0, "R9", "half_o in reset", int'(half_o), 0);
        end
        @(posedge clk);
        #1;
        en_i = 1'b0;
        rst_n = 1'b1;

        run_period(M_LIN, 5'd4, 5, "R9");             // first period after reset
        run_period(M_LIN, 5'd9, 5, "R6");             // new field waits for boundary
        run_period(M_LIN, 5'd9, 10, "R8");
        run_period(M_LIN, 5'd9, 10, "R7", 3, 4);      // gap in first half
        run_period(M_LIN, 5'd9, 10, "R7", 7, 3);      // gap with half_o high
        run_period(M_LIN, 5'd31, 10, "R6");
        run_period(M_LIN, 5'd31, 32, "R1");           // largest linear ratio
        run_period(M_DBL, 5'd2, 32, "R6");            // mode change waits too
        run_period(M_DBL, 5'd2, 6, "R2");
        run_period(M_DBL, 5'h11, 6, "R6");
        run_period(M_DBL, 5'h11, 4, "R2");            // upper field bit ignored
        run_period(M_SHF, 5'd3, 4, "R6");
        run_period(M_SHF, 5'd3, 8, "R3");
        run_period(M_SHF, 5'd7, 8, "R6");
        run_period(M_SHF, 5'd7, 128, "R3");           // largest shift ratio
        run_period(M_SHF, 5'h18, 128, "R6");
        run_period(M_SHF, 5'h18, 1, "R3");            // upper bits ignored -> 2^0
        run_period(M_SHF, 5'd0, 1, "R5");
        run_period(M_LIN, 5'd0, 1, "R5");
        run_period(M_LIN, 5'd0, 1, "R5", 0, 2);       // gap at ratio 1
        run_period(M_FIX, 5'd20, 1, "R6");
        run_period(M_FIX, 5'd20, 3, "R4");
        run_period(M_FIX, 5'd0, 3, "R4");             // field ignored in fixed mode
        run_period(M_LIN, 5'd1, 3, "R6");
        run_period(M_LIN, 5'd1, 2, "R8");             // smallest even ratio
        run_period(M_LIN, 5'd1, 2, "R1");

        drive(1'b0, M_LIN, 5'd1, 1'b0, 1'b0, "R7");
        @(posedge clk);
        @(negedge clk);
        #1;
        check(sb_q.size() == 0, "R1", "scoreboard drained", sb_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule